// File: doc/BRIEF.md
# Descriptor Post-Transfer Update Unit

This block sits beside the engine of a descriptor-driven transfer controller and runs once after every single data transfer. When the engine pulses `xfer_done`, the block samples the live descriptor fields. These are a mode byte, the transfer size code, the destination and source addresses, the transfer counter, the repeat reload size and the start address of the repeat area. One clock later it presents the values to write back into the descriptor, together with the events that the transfer produced.

The destination address steps by the transfer width in the direction that the mode byte selects. It can also be held fixed, and then no write-back is requested. The counter counts down. In repeat operation it reloads on expiry and moves the repeat-area address back to its start. The block decides whether the CPU gets an interrupt and whether the engine should chain to the next descriptor.

Mode byte layout (the engine decodes it in this order): bit 7 enables chaining, bit 6 restricts chaining to counter expiry, bit 5 requests an interrupt after every transfer, bit 4 puts the repeat area on the source side (1) or the destination side (0), and bits 3:2 set the destination mode (00 and 01 fixed, 10 increment, 11 decrement). Bits 1:0 are ignored.

Top module: `desc_post_update`

## Requirements
- R1: After reset all outputs are 0. Each `xfer_done` pulse gives exactly one `upd_valid` pulse, on the next clock. `dst_wb`, `src_wb`, `end_desc`, `irq_req` and `chain_req` are high only together with `upd_valid`. `dst_out`, `src_out` and `cnt_out` hold their values between updates.
- R2: Destination modes 00 and 01 leave `dst_out` equal to the sampled destination address, with `dst_wb` low. This also holds in repeat operation.
- R3: Mode 10 adds 1, 2 or 4 to the destination address for size codes 00, 01 or 10, wrapping modulo 2^AW, with `dst_wb` high.
- R4: Mode 11 subtracts 1, 2 or 4 for size codes 00, 01 or 10, wrapping modulo 2^AW, with `dst_wb` high.
- R5: Size code 11 steps by 4 and sets `size_err`. `size_err` stays set until reset.
- R6: When `rpt_mode` is 0, `cnt_out` is the counter minus 1, wrapping modulo 2^CW. `end_desc` is high exactly when that result is 0.
- R7: When `rpt_mode` is 1, a decremented counter that reaches 0 is replaced by `rpt_size`. The repeat-area address is then restored to `area_start`. On the source side (bit 4 = 1) this gives `src_out`=`area_start` and `src_wb`=1. On the destination side it gives `dst_out`=`area_start` with `dst_wb`=1 when the mode is 10 or 11. `end_desc` is never raised in repeat operation. Otherwise `src_out` equals the sampled source address and `src_wb` is 0.
- R8: With bit 5 at 1 an interrupt is raised after every transfer. With bit 5 at 0 it is raised only with `end_desc`.
- R9: With bit 7 at 0 `chain_req` stays low. With bit 7 at 1 and bit 6 at 0 it is raised after every transfer. With bits 7 and 6 both at 1 it is raised only when the decremented counter is 0.
- R10: `irq_req` is low whenever `chain_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_done | input | 1 | Single-cycle strobe: one data transfer finished |
| rpt_mode | input | 1 | 1 = repeat operation, 0 = normal |
| mode_byte | input | 8 | Descriptor mode byte |
| size_code | input | 2 | Transfer width code |
| dst_in | input | AW | Current destination address |
| src_in | input | AW | Current source address |
| area_start | input | AW | Start address of the repeat area |
| cnt_in | input | CW | Current transfer counter |
| rpt_size | input | CW | Counter reload value for repeat operation |
| upd_valid | output | 1 | Update result valid pulse |
| dst_out | output | AW | Updated destination address |
| dst_wb | output | 1 | Write back destination address |
| src_out | output | AW | Updated source address |
| src_wb | output | 1 | Write back source address (repeat restore) |
| cnt_out | output | CW | Updated counter |
| end_desc | output | 1 | Descriptor finished |
| irq_req | output | 1 | CPU interrupt request pulse |
| chain_req | output | 1 | Continue with next descriptor |
| size_err | output | 1 | Sticky reserved-size flag |

## Verification
Every result is registered one stage after the strobe, so a wrong step, counter or event decode shows on the `upd_valid` cycle of that same transfer and is caught at once. A pulse that leaks outside `upd_valid`, or a held value that drifts, shows on the idle cycle right after. The only state that lasts over many transfers is the sticky error flag. A flag that clears or sets wrongly is caught on the next update by comparing it with the running expectation.

// File: rtl/dpu_pkg.sv
package dpu_pkg;
  typedef enum logic [1:0] {DM_HOLD_A = 2'b00, DM_HOLD_B = 2'b01,
                            DM_UP = 2'b10, DM_DOWN = 2'b11} dst_mode_e;

  typedef struct packed {
    logic      chain_on;
    logic      chain_at_zero;
    logic      irq_every;
    logic      area_is_src;
    dst_mode_e dmode;
  } mode_t;

  function automatic mode_t decode_mode(input logic [7:0] b);
    mode_t m;
    m.chain_on      = b[7];
    m.chain_at_zero = b[6];
    m.irq_every     = b[5];
    m.area_is_src   = b[4];
    m.dmode         = dst_mode_e'(b[3:2]);
    return m;
  endfunction

  function automatic logic [2:0] step_bytes(input logic [1:0] sz);
    case (sz)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dpu_count_path.sv
module dpu_count_path #(
  parameter int CW = 16
) (
  input  logic          rpt_mode,
  input  logic [CW-1:0] cnt_in,
  input  logic [CW-1:0] rpt_size,
  output logic [CW-1:0] cnt_next,
  output logic          hit_zero,
  output logic          restore,
  output logic          finished
);
  localparam logic [CW-1:0] ONE = CW'(1);
  logic [CW-1:0] dec;

  always_comb begin
    dec      = cnt_in - ONE;
    hit_zero = (dec == '0);
    restore  = rpt_mode && hit_zero;
    finished = !rpt_mode && hit_zero;
    cnt_next = restore ? rpt_size : dec;
  end
endmodule

// File: rtl/dpu_addr_path.sv
module dpu_addr_path #(
  parameter int AW = 32
) (
  input  dpu_pkg::mode_t mode,
  input  logic [1:0]     size_code,
  input  logic           restore,
  input  logic [AW-1:0]  dst_in,
  input  logic [AW-1:0]  src_in,
  input  logic [AW-1:0]  area_start,
  output logic [AW-1:0]  dst_next,
  output logic           dst_wb,
  output logic [AW-1:0]  src_next,
  output logic           src_wb,
  output logic           bad_size
);
  import dpu_pkg::*;
  logic [AW-1:0] step;
  logic          dst_moves;
  logic          dst_restore;

  always_comb begin
    step        = AW'(step_bytes(size_code));
    bad_size    = (size_code == 2'b11);
    dst_moves   = (mode.dmode == DM_UP) || (mode.dmode == DM_DOWN);
    dst_restore = restore && !mode.area_is_src && dst_moves;
    dst_wb      = dst_moves;
    if (dst_restore)              dst_next = area_start;
    else if (mode.dmode == DM_UP)   dst_next = dst_in + step;
    else if (mode.dmode == DM_DOWN) dst_next = dst_in - step;
    else                            dst_next = dst_in;
    src_wb   = restore && mode.area_is_src;
    src_next = src_wb ? area_start : src_in;
  end
endmodule

// File: rtl/dpu_event_path.sv
module dpu_event_path (
  input  dpu_pkg::mode_t mode,
  input  logic           hit_zero,
  input  logic           finished,
  output logic           irq,
  output logic           chain
);
  logic irq_raw;
  always_comb begin
    chain   = mode.chain_on && (!mode.chain_at_zero || hit_zero);
    irq_raw = mode.irq_every || finished;
    irq     = irq_raw && !chain;
  end
endmodule

// File: rtl/desc_post_update.sv
module desc_post_update #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xfer_done,
  input  logic          rpt_mode,
  input  logic [7:0]    mode_byte,
  input  logic [1:0]    size_code,
  input  logic [AW-1:0] dst_in,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] area_start,
  input  logic [CW-1:0] cnt_in,
  input  logic [CW-1:0] rpt_size,
  output logic          upd_valid,
  output logic [AW-1:0] dst_out,
  output logic          dst_wb,
  output logic [AW-1:0] src_out,
  output logic          src_wb,
  output logic [CW-1:0] cnt_out,
  output logic          end_desc,
  output logic          irq_req,
  output logic          chain_req,
  output logic          size_err
);
  import dpu_pkg::*;

  mode_t         mode;
  logic [CW-1:0] cnt_n;
  logic          hit_zero, restore, finished;
  logic [AW-1:0] dst_n, src_n;
  logic          dst_wb_n, src_wb_n, bad_size;
  logic          irq_n, chain_n;

  assign mode = decode_mode(mode_byte);

  dpu_count_path #(.CW(CW)) u_cnt (
    .rpt_mode(rpt_mode), .cnt_in(cnt_in), .rpt_size(rpt_size),
    .cnt_next(cnt_n), .hit_zero(hit_zero), .restore(restore), .finished(finished));

  dpu_addr_path #(.AW(AW)) u_addr (
    .mode(mode), .size_code(size_code), .restore(restore),
    .dst_in(dst_in), .src_in(src_in), .area_start(area_start),
    .dst_next(dst_n), .dst_wb(dst_wb_n), .src_next(src_n), .src_wb(src_wb_n),
    .bad_size(bad_size));

  dpu_event_path u_evt (
    .mode(mode), .hit_zero(hit_zero), .finished(finished),
    .irq(irq_n), .chain(chain_n));

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_valid <= 1'b0;
      dst_out   <= '0;
      dst_wb    <= 1'b0;
      src_out   <= '0;
      src_wb    <= 1'b0;
      cnt_out   <= '0;
      end_desc  <= 1'b0;
      irq_req   <= 1'b0;
      chain_req <= 1'b0;
      size_err  <= 1'b0;
    end else begin
      upd_valid <= xfer_done;
      dst_wb    <= xfer_done && dst_wb_n;
      src_wb    <= xfer_done && src_wb_n;
      end_desc  <= xfer_done && finished;
      irq_req   <= xfer_done && irq_n;
      chain_req <= xfer_done && chain_n;
      if (xfer_done) begin
        dst_out <= dst_n;
        src_out <= src_n;
        cnt_out <= cnt_n;
        if (bad_size) size_err <= 1'b1;
      end
    end
  end

  // R1
  no_stray_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !xfer_done |=> !upd_valid && !irq_req && !chain_req && !end_desc && !dst_wb && !src_wb);
  // R1
  hold_dst_chk: assert property (@(posedge clk) disable iff (rst)
    !xfer_done |=> $stable(dst_out) && $stable(cnt_out));
  // R2
  fixed_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_done && !mode_byte[3] |=> !dst_wb && dst_out == $past(dst_in));
  // R3
  inc_byte_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_done && !rpt_mode && mode_byte[3:2] == 2'b10 && size_code == 2'b00
    |=> dst_out == $past(dst_in) + AW'(1));
  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    size_err |=> size_err);
  // R5
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_done && size_code == 2'b11 |=> size_err);
  // R7
  rpt_no_end_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_done && rpt_mode |=> !end_desc);
  // R9
  chain_off_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_done && !mode_byte[7] |=> !chain_req);
  // R10
  irq_vs_chain_chk: assert property (@(posedge clk) disable iff (rst)
    chain_req |-> !irq_req);
endmodule

// File: tb/sim_desc_post_update.sv
`timescale 1ns/1ps
module sim_desc_post_update;
  localparam int AW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          xfer_done = 1'b0, rpt_mode = 1'b0;
  logic [7:0]    mode_byte = '0;
  logic [1:0]    size_code = '0;
  logic [AW-1:0] dst_in = '0, src_in = '0, area_start = '0;
  logic [CW-1:0] cnt_in = '0, rpt_size = '0;
  logic          upd_valid, dst_wb, src_wb, end_desc, irq_req, chain_req, size_err;
  logic [AW-1:0] dst_out, src_out;
  logic [CW-1:0] cnt_out;

  int checks = 0, errors = 0;
  logic exp_err = 1'b0;

  always #4 clk = ~clk;

  desc_post_update #(.AW(AW), .CW(CW)) u0 (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic rm, input logic [7:0] mb, input logic [1:0] sz,
                       input logic [AW-1:0] d, input logic [AW-1:0] s, input logic [AW-1:0] a,
                       input logic [CW-1:0] c, input logic [CW-1:0] r);
    logic [AW-1:0] st, e_dst, e_src;
    logic [CW-1:0] dec, e_cnt;
    logic z, rs, fin, e_dwb, e_swb, e_ch, e_irq;
    @(negedge clk);
    rpt_mode = rm; mode_byte = mb; size_code = sz; dst_in = d; src_in = s;
    area_start = a; cnt_in = c; rpt_size = r; xfer_done = 1'b1;
    st  = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    dec = c - 1'b1;
    z   = (dec == 0);
    rs  = rm && z;
    fin = !rm && z;
    e_cnt = rs ? r : dec;
    e_dwb = mb[3];
    if (rs && !mb[4] && mb[3]) e_dst = a;
    else if (mb[3:2] == 2'b10) e_dst = d + st;
    else if (mb[3:2] == 2'b11) e_dst = d - st;
    else e_dst = d;
    e_swb = rs && mb[4];
    e_src = e_swb ? a : s;
    e_ch  = mb[7] && (!mb[6] || z);
    e_irq = (mb[5] || fin) && !e_ch;
    if (sz == 2'b11) exp_err = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    chk("R1 valid", upd_valid, 1);
    chk("R2/R3/R4 dst", dst_out, e_dst);
    chk("R2 dst_wb", dst_wb, e_dwb);
    chk("R7 src", src_out, e_src);
    chk("R7 src_wb", src_wb, e_swb);
    chk("R6/R7 cnt", cnt_out, e_cnt);
    chk("R6 end", end_desc, fin);
    chk("R8/R10 irq", irq_req, e_irq);
    chk("R9 chain", chain_req, e_ch);
    chk("R5 err", size_err, exp_err);
    @(negedge clk);
    chk("R1 idle pulses", {upd_valid, dst_wb, src_wb, end_desc, irq_req, chain_req}, 0);
    chk("R1 hold", {dst_out, cnt_out}, {e_dst, e_cnt});
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset", {upd_valid, dst_out, dst_wb, src_out, src_wb, cnt_out,
                     end_desc, irq_req, chain_req, size_err}, 0);
    // R3 increments per size
    apply(0, 8'h08, 2'b00, 32'h100, 0, 0, 16'd5, 0);
    apply(0, 8'h08, 2'b01, 32'h100, 0, 0, 16'd5, 0);
    apply(0, 8'h08, 2'b10, 32'hFFFF_FFFE, 0, 0, 16'd5, 0);
    // R4 decrement with wrap
    apply(0, 8'h0C, 2'b10, 32'h2, 0, 0, 16'd5, 0);
    apply(0, 8'h0C, 2'b01, 32'h10, 0, 0, 16'd5, 0);
    // R2 fixed modes
    apply(0, 8'h00, 2'b10, 32'h55, 0, 0, 16'd5, 0);
    apply(0, 8'h04, 2'b00, 32'h55, 0, 0, 16'd1, 0);
    // R6 end and counter wrap from 0
    apply(0, 8'h08, 2'b00, 32'h0, 0, 0, 16'd1, 0);
    apply(0, 8'h08, 2'b00, 32'h0, 0, 0, 16'd0, 0);
    // R8 interrupt each vs at end
    apply(0, 8'h28, 2'b00, 32'h0, 0, 0, 16'd9, 0);
    apply(0, 8'h08, 2'b00, 32'h0, 0, 0, 16'd9, 0);
    // R9 chain always / at zero only; R10 suppression
    apply(0, 8'hA8, 2'b00, 32'h0, 0, 0, 16'd9, 0);
    apply(0, 8'hC8, 2'b00, 32'h0, 0, 0, 16'd9, 0);
    apply(0, 8'hC8, 2'b00, 32'h0, 0, 0, 16'd1, 0);
    // R7 repeat restore on each side, fixed dest stays
    apply(1, 8'h08, 2'b00, 32'h400, 32'h900, 32'h3F0, 16'd1, 16'd8);
    apply(1, 8'h18, 2'b00, 32'h400, 32'h900, 32'h3F0, 16'd1, 16'd8);
    apply(1, 8'h00, 2'b00, 32'h400, 32'h900, 32'h3F0, 16'd1, 16'd8);
    apply(1, 8'h28, 2'b00, 32'h400, 32'h900, 32'h3F0, 16'd4, 16'd8);
    // R5 reserved size, then sticky
    apply(0, 8'h08, 2'b11, 32'h20, 0, 0, 16'd7, 0);
    apply(0, 8'h0C, 2'b00, 32'h20, 0, 0, 16'd7, 0);
    for (int i = 0; i < 300; i++) begin
      logic [CW-1:0] c;
      c = ($urandom % 4 == 0) ? CW'($urandom % 3) : CW'($urandom);
      apply(1'($urandom), 8'($urandom), 2'($urandom % 3), $urandom, $urandom,
            $urandom, c, CW'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule